// File: doc/BRIEF.md
# Deferred Beam Interlock Arbiter

This block turns fault information from a beam line into one interlock decision. Upstream checkers, which are not part of this block, report limit violations as single-cycle pulses. Two level flags report whether the target temperature or the average beam intensity sits close to its safe limit. A strobe marks the end of every macro pulse. Twelve binary interlock inputs from external plant systems are also accepted. The block drives one main interlock level, eight identical copies for other systems, and a two-bit status code.

An external interlock bit trips the output at once. A violation pulse is handled differently. If the block is healthy and both margins are comfortable, the violation is treated as a possible glitch and the block enters a suspect state. It then watches the following macro pulse. The interlock trips if the violation recurs in that pulse, or if either near-limit flag rises while the block is suspect. If the following pulse ends cleanly, the event is taken as noise and the block returns to normal.

Once tripped, the interlock holds until a clear request arrives in a cycle with no violation and no external bit active. All inputs are synchronous to `clk`. The reset is asynchronous and active low, and it is released internally after two clock edges.

Top module: `beam_ilk_arbiter`

## Requirements
- R1: While reset is active, and for the cycles after it until the first fault, the status is 00 and the main interlock and all eight copies are low.
- R2: Each of the eight external-system interlock outputs equals the main interlock output in every cycle.
- R3: The status code is 00 for normal, 01 for suspect and 10 for tripped, and never 11. The main interlock is high exactly when the status is 10, and both change on the clock edge that samples the causing inputs.
- R4: If any of the twelve external interlock bits is high at a clock edge, the block is tripped after that edge, whatever its state.
- R5: A violation in normal state while the temperature or the intensity near-limit flag is high trips the block at once. Either near-limit flag high while the block is suspect also trips it.
- R6: A violation in normal state with both near-limit flags low moves the block to suspect. Further violations before the first macro-pulse-end strobe are part of the same event and leave it suspect.
- R7: While suspect, after one end strobe has been seen, a violation in the following macro pulse trips the block. This includes a violation in the same cycle as that pulse's end strobe.
- R8: While suspect, the second end strobe with no violation returns the block to normal. A violation that arrives together with an end strobe counts as already past the first strobe, so the next clean strobe ends the event.
- R9: The trip is latched. It is released to normal only by the clear request in a cycle with no violation and no external bit high. A clear in normal or suspect state has no effect.
- R10: Each of the violation inputs has the same effect; the block acts on their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol_i | input | N_VIOL (4) | Limit-violation pulses from process-variable checkers |
| temp_near_i | input | 1 | Target temperature close to its safe limit |
| inten_near_i | input | 1 | Average beam intensity close to its safe limit |
| mp_end_i | input | 1 | One-cycle strobe at the end of each macro pulse |
| ext_ilk_i | input | N_EXT (12) | Binary interlock requests from external systems |
| clear_i | input | 1 | Request to release a latched trip |
| ilk_o | output | 1 | Main interlock level |
| ilk_copy_o | output | N_COPY (8) | Interlock copies for external systems |
| status_o | output | 2 | Decision state: 00 normal, 01 suspect, 10 tripped |

## Verification
A corrupted decision state shows on `status_o` and on `ilk_o` at the first edge after it occurs. A lost or stuck tracker of the macro-pulse window is harder to see: it appears only when the next end strobe or violation arrives in suspect state. It then shows as an early return to normal, a late return, or a trip that should not happen. For this reason the random stimulus mixes strobes, violations and near flags densely, and every cycle is compared with a state model. Directed sequences cover violations that coincide with strobes and clears that coincide with faults, because those cases separate one priority order from another within a single cycle.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    ILK_NORMAL  = 2'b00,
    ILK_SUSPECT = 2'b01,
    ILK_TRIPPED = 2'b10
  } ilk_state_e;

endpackage

// File: rtl/ilk_rst_sync.sv
module ilk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ilk_fault_merge.sv
module ilk_fault_merge #(
  parameter int N_VIOL = 4,
  parameter int N_EXT  = 12
) (
  input  logic [N_VIOL-1:0] viol_i,
  input  logic [N_EXT-1:0]  ext_ilk_i,
  input  logic              temp_near_i,
  input  logic              inten_near_i,
  output logic              viol_any,
  output logic              ext_any,
  output logic              near_any
);

  // Running OR chains, one stage per input bit
  logic [N_VIOL:0] viol_chain;
  logic [N_EXT:0]  ext_chain;

  assign viol_chain[0] = 1'b0;
  assign ext_chain[0]  = 1'b0;

  for (genvar gv = 0; gv < N_VIOL; gv++) begin : g_viol
    assign viol_chain[gv+1] = viol_chain[gv] | viol_i[gv];
  end

  for (genvar ge = 0; ge < N_EXT; ge++) begin : g_ext
    assign ext_chain[ge+1] = ext_chain[ge] | ext_ilk_i[ge];
  end

  assign viol_any = viol_chain[N_VIOL];
  assign ext_any  = ext_chain[N_EXT];
  assign near_any = temp_near_i | inten_near_i;

endmodule

// File: rtl/ilk_decide_fsm.sv
module ilk_decide_fsm
  import ilk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       viol_any,
  input  logic       ext_any,
  input  logic       near_any,
  input  logic       mp_end_i,
  input  logic       clear_i,
  output ilk_state_e state_q,
  output ilk_state_e state_d
);

  // window_q: set once the pulse holding the first violation has ended
  logic window_q, window_d;
  logic upd_en;

  always_comb begin
    state_d  = state_q;
    window_d = window_q;
    if (ext_any) begin
      state_d  = ILK_TRIPPED;
      window_d = 1'b0;
    end else begin
      unique case (state_q)
        ILK_NORMAL: begin
          window_d = 1'b0;
          if (viol_any) begin
            if (near_any) begin
              state_d = ILK_TRIPPED;
            end else begin
              state_d  = ILK_SUSPECT;
              window_d = mp_end_i;
            end
          end
        end
        ILK_SUSPECT: begin
          if (near_any) begin
            state_d  = ILK_TRIPPED;
            window_d = 1'b0;
          end else if (window_q) begin
            if (viol_any) begin
              state_d  = ILK_TRIPPED;
              window_d = 1'b0;
            end else if (mp_end_i) begin
              state_d  = ILK_NORMAL;
              window_d = 1'b0;
            end
          end else if (mp_end_i) begin
            window_d = 1'b1;
          end
        end
        ILK_TRIPPED: begin
          window_d = 1'b0;
          if (clear_i && !viol_any) begin
            state_d = ILK_NORMAL;
          end
        end
        default: begin
          state_d  = ILK_TRIPPED;
          window_d = 1'b0;
        end
      endcase
    end
  end

  assign upd_en = (state_d != state_q) || (window_d != window_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ILK_NORMAL;
      window_q <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      window_q <= window_d;
    end
  end

endmodule

// File: rtl/ilk_fanout.sv
module ilk_fanout #(
  parameter int N_COPY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip_d,
  output logic              ilk_o,
  output logic [N_COPY-1:0] copy_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilk_o <= 1'b0;
    end else begin
      ilk_o <= trip_d;
    end
  end

  // One flop per copy so each external line has its own driver
  for (genvar gc = 0; gc < N_COPY; gc++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        copy_o[gc] <= 1'b0;
      end else begin
        copy_o[gc] <= trip_d;
      end
    end
  end

endmodule

// File: rtl/beam_ilk_arbiter.sv
module beam_ilk_arbiter
  import ilk_pkg::*;
#(
  parameter int N_VIOL    = 4,
  parameter int N_EXT     = 12,
  parameter int N_COPY    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_VIOL-1:0] viol_i,
  input  logic              temp_near_i,
  input  logic              inten_near_i,
  input  logic              mp_end_i,
  input  logic [N_EXT-1:0]  ext_ilk_i,
  input  logic              clear_i,
  output logic              ilk_o,
  output logic [N_COPY-1:0] ilk_copy_o,
  output logic [1:0]        status_o
);

  logic       rst_sync_n;
  logic       viol_any, ext_any, near_any;
  ilk_state_e state_q, state_d;
  logic       trip_d;

  ilk_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ilk_fault_merge #(.N_VIOL(N_VIOL), .N_EXT(N_EXT)) u_merge (
    .viol_i       (viol_i),
    .ext_ilk_i    (ext_ilk_i),
    .temp_near_i  (temp_near_i),
    .inten_near_i (inten_near_i),
    .viol_any     (viol_any),
    .ext_any      (ext_any),
    .near_any     (near_any)
  );

  ilk_decide_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .viol_any (viol_any),
    .ext_any  (ext_any),
    .near_any (near_any),
    .mp_end_i (mp_end_i),
    .clear_i  (clear_i),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  assign trip_d = (state_d == ILK_TRIPPED);

  ilk_fanout #(.N_COPY(N_COPY)) u_fan (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .trip_d (trip_d),
    .ilk_o  (ilk_o),
    .copy_o (ilk_copy_o)
  );

  assign status_o = state_q;

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int N_VIOL = 4,
  parameter int N_EXT  = 12,
  parameter int N_COPY = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_VIOL-1:0] viol_i,
  input logic              temp_near_i,
  input logic              inten_near_i,
  input logic [N_EXT-1:0]  ext_ilk_i,
  input logic              clear_i,
  input logic              ilk_o,
  input logic [N_COPY-1:0] ilk_copy_o,
  input logic [1:0]        status_o
);

  p_copy_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_copy_o == {N_COPY{ilk_o}});

  p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'b11) && (ilk_o == (status_o == 2'b10)));

  p_ext_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_ilk_i) |=> ilk_o);

  p_near_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o == 2'b01) && (temp_near_i || inten_near_i)) |=> ilk_o);

  p_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o == 2'b00) && (|viol_i) && !temp_near_i && !inten_near_i && !(|ext_ilk_i))
      |=> (status_o == 2'b01));

  p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ilk_o && (!clear_i || (|viol_i) || (|ext_ilk_i))) |=> ilk_o);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ilk_o && clear_i && !(|viol_i) && !(|ext_ilk_i)) |=> (status_o == 2'b00));

endmodule

bind beam_ilk_arbiter ilk_checker #(
  .N_VIOL (N_VIOL),
  .N_EXT  (N_EXT),
  .N_COPY (N_COPY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .viol_i       (viol_i),
  .temp_near_i  (temp_near_i),
  .inten_near_i (inten_near_i),
  .ext_ilk_i    (ext_ilk_i),
  .clear_i      (clear_i),
  .ilk_o        (ilk_o),
  .ilk_copy_o   (ilk_copy_o),
  .status_o     (status_o)
);

// File: tb/tb_beam_ilk_arbiter.sv
`timescale 1ns/1ps
module tb_beam_ilk_arbiter;

  localparam int NV = 4;
  localparam int NE = 12;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NV-1:0] viol;
  logic          tnear, inear, mpe, clr;
  logic [NE-1:0] ext;
  logic          ilk;
  logic [NC-1:0] copies;
  logic [1:0]    status;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // bench model state
  logic [1:0] m_st;
  logic       m_win;

  always #2.5 clk = ~clk;

  beam_ilk_arbiter dut (
    .clk(clk), .rst_n(rst_n), .viol_i(viol), .temp_near_i(tnear),
    .inten_near_i(inear), .mp_end_i(mpe), .ext_ilk_i(ext), .clear_i(clr),
    .ilk_o(ilk), .ilk_copy_o(copies), .status_o(status)
  );

  // Next state from the requirements: returns {state, window}
  function automatic logic [2:0] model_next(logic [1:0] st, logic win,
      logic v, logic nr, logic me, logic ex, logic cl);
    logic [1:0] ns = st;
    logic       nw = win;
    if (ex) begin ns = 2'b10; nw = 1'b0; end                        // R4
    else if (st == 2'b00) begin
      nw = 1'b0;
      if (v && nr) ns = 2'b10;                                      // R5
      else if (v) begin ns = 2'b01; nw = me; end                    // R6, R8
    end else if (st == 2'b01) begin
      if (nr) begin ns = 2'b10; nw = 1'b0; end                      // R5
      else if (win && v) begin ns = 2'b10; nw = 1'b0; end           // R7
      else if (win && me) begin ns = 2'b00; nw = 1'b0; end          // R8
      else if (!win && me) nw = 1'b1;                               // R6
    end else begin
      nw = 1'b0;
      if (cl && !v) ns = 2'b00;                                     // R9
    end
    return {ns, nw};
  endfunction

  task automatic check(string req, logic [1:0] exp_st);
    checks++;
    if (status !== exp_st || ilk !== (exp_st == 2'b10) ||
        copies !== {NC{exp_st == 2'b10}}) begin
      fails++;
      $display("FAIL %s cycle %0d: status=%b ilk=%b copies=%b expected status=%b ilk=%b",
               req, cyc, status, ilk, copies, exp_st, exp_st == 2'b10);
    end
  endtask

  task automatic idle_inputs();
    viol = '0; tnear = 0; inear = 0; mpe = 0; ext = '0; clr = 0;
  endtask

  // Drive one cycle, advance model, check after the edge
  task automatic step(string req, logic [NV-1:0] v, logic tn, logic in_,
      logic me, logic [NE-1:0] ex, logic cl);
    logic [2:0] nx;
    @(negedge clk);
    viol = v; tnear = tn; inear = in_; mpe = me; ext = ex; clr = cl;
    nx = model_next(m_st, m_win, |v, tn | in_, me, |ex, cl);
    @(posedge clk);
    #1;
    m_st  = nx[2:1];
    m_win = nx[0];
    check(req, m_st);
  endtask

  task automatic go_normal();
    step("R9", '0, 0, 0, 0, '0, 1);
    step("R9", '0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: expired at cycle %0d expected completion", cnt);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    void'($urandom(32'd20240517));
    idle_inputs();
    m_st = 2'b00; m_win = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", 2'b00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", 2'b00);
    step("R1", '0, 0, 0, 1, '0, 1);   // clear and strobe in normal: no effect

    // R4: each external bit alone trips; from normal
    for (int i = 0; i < NE; i++) begin
      step("R4", '0, 0, 0, 0, NE'(1) << i, 0);
      step("R9", '0, 0, 0, 0, '0, 0);           // latched
      go_normal();
    end

    // R9: clear blocked by a violation or an external bit
    step("R4", '0, 0, 0, 0, 12'h800, 0);
    step("R9", 4'b0010, 0, 0, 0, '0, 1);
    step("R9", '0, 0, 0, 0, 12'h001, 1);
    go_normal();

    // R5: violation with temperature near, then intensity near
    step("R5", 4'b0001, 1, 0, 0, '0, 0);
    go_normal();
    step("R5", 4'b1000, 0, 1, 0, '0, 0);
    go_normal();

    // R10/R6/R8: each violation bit -> suspect, then two clean strobes -> normal
    for (int i = 0; i < NV; i++) begin
      step("R10", NV'(1) << i, 0, 0, 0, '0, 0);
      step("R6", 4'b0100, 0, 0, 0, '0, 0);        // same pulse: ignored
      step("R9", '0, 0, 0, 0, '0, 1);             // clear in suspect: no effect
      step("R6", '0, 0, 0, 1, '0, 0);
      step("R8", '0, 0, 0, 0, '0, 0);
      step("R8", '0, 0, 0, 1, '0, 0);
    end

    // R7: recurrence in next pulse, together with its end strobe
    step("R6", 4'b0001, 0, 0, 0, '0, 0);
    step("R6", '0, 0, 0, 1, '0, 0);
    step("R7", 4'b0001, 0, 0, 1, '0, 0);
    go_normal();

    // R8: violation together with a strobe, one clean strobe ends it
    step("R8", 4'b0010, 0, 0, 1, '0, 0);
    step("R8", '0, 0, 0, 1, '0, 0);

    // R5: near flag rising while suspect
    step("R6", 4'b0001, 0, 0, 0, '0, 0);
    step("R5", '0, 0, 1, 0, '0, 0);
    go_normal();

    // R4: external bit while suspect
    step("R6", 4'b0001, 0, 0, 0, '0, 0);
    step("R4", '0, 0, 0, 0, 12'h040, 0);
    go_normal();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [NV-1:0] v;
      logic [NE-1:0] ex;
      v  = ($urandom % 6 == 0) ? NV'($urandom) : '0;
      ex = ($urandom % 50 == 0) ? (NE'(1) << ($urandom % NE)) : '0;
      step("R3", v, ($urandom % 9 == 0), ($urandom % 9 == 0),
           ($urandom % 5 == 0), ex, ($urandom % 4 == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule